// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel that hangs off a shared timer counter. The counter can count up, down, or alternate between the two. The channel itself holds no count. It sees the counter value and the direction on every clock, and it sees the update strobe that the counter raises when it reloads. A mode input selects what the channel does with them: in capture mode it timestamps events on an external pin, and in compare mode it drives an output pin.

In capture mode the pin goes through four stages in turn:

- a synchroniser;
- a digital filter that needs a run of equal samples;
- edge qualification (rising, falling or both);
- a divider that passes only every 1st, 2nd, 4th or 8th qualified edge.

The edge that passes the divider copies the counter value into the channel register.

In compare mode the channel register is compared against the counter. The channel offers two PWM modes. In both, the counter's reload value fixes the period and the channel register fixes the duty. With an up/down counter the waveform comes out center-aligned, and a polarity bit sets the active level of the pin. Captures and compare matches set a sticky status flag. A capture that lands while that flag is still set also raises an overcapture flag.

Top module: `tmr_cc_chan`

## Requirements
- R1: While `rst_ni` is low, `ccr_o`, `flag_o` and `ovc_o` read 0 and `out_o` equals `cfg_pol_i`.
- R2: The pin passes two synchroniser flops. The filter then accepts a new level only after N consecutive differing samples, with N = 2^`cfg_flt_i` (1, 2, 4 or 8). With the pin changed just before clock edge k, the capture happens at edge k+1+N. A pulse shorter than N cycles is ignored.
- R3: `cfg_edge_i` selects the qualified edge: 0 rising, 1 falling, 2 or 3 both.
- R4: With `cfg_capture_i`=1, a capture happens on every 2^`cfg_psc_i`-th qualified edge (1, 2, 4 or 8).
- R5: A capture copies `cnt_i` (as sampled at the capturing edge) into `ccr_o` and sets `flag_o`.
- R6: A capture while `flag_o` is already 1 sets `ovc_o`.
- R7: `flag_clr_i` clears both `flag_o` and `ovc_o` on the next edge. A simultaneous set wins.
- R8: In compare mode, `flag_o` is set once each time `cnt_i` becomes equal to `ccr_o`. Holding the equality does not set it again.
- R9: `cfg_mode_i` selects the output reference in compare mode, registered one cycle after `cnt_i`:
  - 0 holds;
  - 1 goes high on a match;
  - 2 goes low on a match;
  - 3 toggles on a match;
  - 4 is forced low;
  - 5 is forced high;
  - 6 is PWM A;
  - 7 is PWM B.
- R10: In PWM A the reference is high while `cnt_i` < `ccr_o` when counting up (`dir_down_i`=0), and while `cnt_i` <= `ccr_o` when counting down. PWM B is the inverse.
- R11: `out_o` is the reference XOR `cfg_pol_i`.
- R12: With `cfg_preload_i`=0, a write through `ccr_we_i` reaches `ccr_o` on the next edge. With `cfg_preload_i`=1, it is held until `upd_i`.
- R13: In capture mode, `ccr_we_i` writes are ignored and `out_o` stays at `cfg_pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared counter value |
| dir_down_i | input | 1 | Counter direction, 1 = down |
| upd_i | input | 1 | Counter update event |
| cfg_capture_i | input | 1 | 1 = capture mode, 0 = compare mode |
| cfg_mode_i | input | 3 | Compare output mode |
| cfg_pol_i | input | 1 | Output polarity, 1 = active low |
| cfg_preload_i | input | 1 | Compare register preload enable |
| cfg_edge_i | input | 2 | Capture edge select |
| cfg_flt_i | input | FLT_SEL_W | Filter length select |
| cfg_psc_i | input | PSC_SEL_W | Capture edge divider select |
| ccr_we_i | input | 1 | Channel register write strobe |
| ccr_wdata_i | input | CNT_W | Channel register write data |
| flag_clr_i | input | 1 | Clear capture/compare and overcapture flags |
| in_i | input | 1 | Capture input pin |
| out_o | output | 1 | Compare output pin |
| ccr_o | output | CNT_W | Active channel register |
| flag_o | output | 1 | Capture/compare flag |
| ovc_o | output | 1 | Overcapture flag |

## Verification
The assertions assume that the configuration inputs, in particular `cfg_capture_i`, `cfg_mode_i` and `cfg_pol_i`, change only between clock edges and are held for at least a cycle. The assertions also assume that `flag_clr_i` is a deliberate pulse rather than a level held high. The stimulus reconfigures the channel only at falling clock edges. It changes the pin no faster than every 16 cycles, so every filter and divider setting settles before the next edge arrives. In compare tests it holds each counter value for two cycles, so a one-shot match can be told apart from a repeated one.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN       = 3'd0,
    OC_SET_ON_MATCH = 3'd1,
    OC_CLR_ON_MATCH = 3'd2,
    OC_TOGGLE       = 3'd3,
    OC_FORCE_LO     = 3'd4,
    OC_FORCE_HI     = 3'd5,
    OC_PWM_A        = 3'd6,
    OC_PWM_B        = 3'd7
  } oc_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_BOTH  = 2'd2,
    EDGE_BOTH2 = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/cc_in_filter.sv
module cc_in_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int MAX_N = 1 << ((1 << SEL_W) - 1);
  localparam int RUN_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic                   lvl_q;
  logic [RUN_W-1:0]       run_q;
  logic [RUN_W-1:0]       run_lim;
  logic                   accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], in_i};
  end

  assign smp     = sync_q[SYNC_STAGES-1];
  assign run_lim = RUN_W'((1 << sel_i) - 1);
  assign accept  = (smp != lvl_q) && (run_q == run_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (smp == lvl_q) begin
      run_q <= '0;
    end else if (accept) begin
      lvl_q <= smp;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign rise_o = accept &  smp;
  assign fall_o = accept & ~smp;
endmodule

// File: rtl/cc_in_presc.sv
module cc_in_presc
  import tmr_cc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  edge_sel_e        edge_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cap_o
);
  localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
  localparam int CW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic          qual;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (edge_i)
      EDGE_RISE: qual = rise_i;
      EDGE_FALL: qual = fall_i;
      default:   qual = rise_i | fall_i;
    endcase
    qual = qual & en_i;
  end

  assign lim   = CW'((1 << sel_i) - 1);
  assign cap_o = qual && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (cap_o)    cnt_q <= '0;
    else if (qual)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cc_oc_gen.sv
module cc_oc_gen
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  oc_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ccr_i,
  input  logic             dir_down_i,
  output logic             match_evt_o,
  output logic             ref_o
);
  logic match, match_q, below, ref_q;

  assign match       = (cnt_i == ccr_i);
  assign match_evt_o = en_i && match && !match_q;
  // down-counting includes equality so the duty is symmetric in center-aligned use
  assign below       = dir_down_i ? (cnt_i <= ccr_i) : (cnt_i < ccr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= en_i && match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
    end else if (!en_i) begin
      ref_q <= 1'b0;
    end else begin
      unique case (mode_i)
        OC_FROZEN:       ref_q <= ref_q;
        OC_SET_ON_MATCH: if (match_evt_o) ref_q <= 1'b1;
        OC_CLR_ON_MATCH: if (match_evt_o) ref_q <= 1'b0;
        OC_TOGGLE:       if (match_evt_o) ref_q <= ~ref_q;
        OC_FORCE_LO:     ref_q <= 1'b0;
        OC_FORCE_HI:     ref_q <= 1'b1;
        OC_PWM_A:        ref_q <= below;
        OC_PWM_B:        ref_q <= ~below;
        default:         ref_q <= ref_q;
      endcase
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/cc_reg.sv
module cc_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_mode_i,
  input  logic             cap_evt_i,
  input  logic             match_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             preload_i,
  input  logic             upd_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic             flag_o,
  output logic             ovc_o
);
  logic [CNT_W-1:0] ccr_q, shadow_q;
  logic             flag_q, ovc_q, set_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (cap_mode_i) begin
        if (cap_evt_i) ccr_q <= cnt_i;
      end else begin
        if (we_i) shadow_q <= wdata_i;
        if (!preload_i && we_i)     ccr_q <= wdata_i;
        else if (preload_i && upd_i) ccr_q <= shadow_q;
      end
    end
  end

  assign set_flag = (cap_mode_i && cap_evt_i) || (!cap_mode_i && match_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      ovc_q  <= 1'b0;
    end else begin
      if (set_flag)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      if (cap_mode_i && cap_evt_i && flag_q) ovc_q <= 1'b1;
      else if (clr_i)                        ovc_q <= 1'b0;
    end
  end

  assign ccr_o  = ccr_q;
  assign flag_o = flag_q;
  assign ovc_o  = ovc_q;
endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FLT_SEL_W   = 2,
  parameter int PSC_SEL_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 dir_down_i,
  input  logic                 upd_i,
  input  logic                 cfg_capture_i,
  input  logic [2:0]           cfg_mode_i,
  input  logic                 cfg_pol_i,
  input  logic                 cfg_preload_i,
  input  logic [1:0]           cfg_edge_i,
  input  logic [FLT_SEL_W-1:0] cfg_flt_i,
  input  logic [PSC_SEL_W-1:0] cfg_psc_i,
  input  logic                 ccr_we_i,
  input  logic [CNT_W-1:0]     ccr_wdata_i,
  input  logic                 flag_clr_i,
  input  logic                 in_i,
  output logic                 out_o,
  output logic [CNT_W-1:0]     ccr_o,
  output logic                 flag_o,
  output logic                 ovc_o
);
  logic rise, fall, cap_evt, match_evt, oc_ref;
  logic [CNT_W-1:0] ccr_act;

  cc_in_filter #(.SYNC_STAGES(SYNC_STAGES), .SEL_W(FLT_SEL_W)) u_flt (
    .clk_i, .rst_ni, .in_i, .sel_i(cfg_flt_i), .rise_o(rise), .fall_o(fall)
  );

  cc_in_presc #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i, .rst_ni, .en_i(cfg_capture_i), .rise_i(rise), .fall_i(fall),
    .edge_i(edge_sel_e'(cfg_edge_i)), .sel_i(cfg_psc_i), .cap_o(cap_evt)
  );

  cc_oc_gen #(.CNT_W(CNT_W)) u_oc (
    .clk_i, .rst_ni, .en_i(!cfg_capture_i), .mode_i(oc_mode_e'(cfg_mode_i)),
    .cnt_i, .ccr_i(ccr_act), .dir_down_i, .match_evt_o(match_evt), .ref_o(oc_ref)
  );

  cc_reg #(.CNT_W(CNT_W)) u_reg (
    .clk_i, .rst_ni, .cap_mode_i(cfg_capture_i), .cap_evt_i(cap_evt),
    .match_evt_i(match_evt), .cnt_i, .preload_i(cfg_preload_i), .upd_i,
    .we_i(ccr_we_i), .wdata_i(ccr_wdata_i), .clr_i(flag_clr_i),
    .ccr_o(ccr_act), .flag_o, .ovc_o
  );

  assign ccr_o = ccr_act;
  assign out_o = oc_ref ^ cfg_pol_i;
endmodule

// File: rtl/tmr_cc_chan_sva.sv
module tmr_cc_chan_sva #(
  parameter int CNT_W     = 16,
  parameter int FLT_SEL_W = 2,
  parameter int PSC_SEL_W = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CNT_W-1:0]     cnt_i,
  input logic                 dir_down_i,
  input logic                 upd_i,
  input logic                 cfg_capture_i,
  input logic [2:0]           cfg_mode_i,
  input logic                 cfg_pol_i,
  input logic                 cfg_preload_i,
  input logic [1:0]           cfg_edge_i,
  input logic [FLT_SEL_W-1:0] cfg_flt_i,
  input logic [PSC_SEL_W-1:0] cfg_psc_i,
  input logic                 ccr_we_i,
  input logic [CNT_W-1:0]     ccr_wdata_i,
  input logic                 flag_clr_i,
  input logic                 in_i,
  input logic                 out_o,
  input logic [CNT_W-1:0]     ccr_o,
  input logic                 flag_o,
  input logic                 ovc_o
);
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  p_ovc_needs_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovc_o) |-> $past(flag_o));

  p_preload_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_capture_i && cfg_preload_i && !upd_i) |-> $stable(ccr_o));

  p_pwm_a_up_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_capture_i && cfg_mode_i == 3'd6 && !dir_down_i)
      |-> ((out_o ^ cfg_pol_i) == $past(cnt_i < ccr_o)));

  p_force_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!cfg_capture_i && cfg_mode_i == 3'd5) |-> (out_o == !cfg_pol_i));

  p_cap_out_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_capture_i && $past(cfg_capture_i) |-> (out_o == cfg_pol_i));
endmodule

bind tmr_cc_chan tmr_cc_chan_sva #(
  .CNT_W(CNT_W), .FLT_SEL_W(FLT_SEL_W), .PSC_SEL_W(PSC_SEL_W)
) u_sva (.*);

// File: tb/tmr_cc_chan_bench.sv
`timescale 1ns/1ps
module tmr_cc_chan_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic dir_down_i = 1'b0, upd_i = 1'b0, cfg_capture_i = 1'b1;
  logic [2:0] cfg_mode_i = 3'd0;
  logic cfg_pol_i = 1'b0, cfg_preload_i = 1'b0;
  logic [1:0] cfg_edge_i = 2'd0, cfg_flt_i = 2'd0, cfg_psc_i = 2'd0;
  logic ccr_we_i = 1'b0;
  logic [CNT_W-1:0] ccr_wdata_i = '0;
  logic flag_clr_i, in_i = 1'b0;
  logic out_o, flag_o, ovc_o;
  logic [CNT_W-1:0] ccr_o;

  logic mon_clr = 1'b0, man_clr = 1'b0, mon_en = 1'b0, free_run = 1'b0;
  assign flag_clr_i = mon_clr | man_clr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [CNT_W-1:0] exp_q[$];

  always #10 clk = ~clk;

  tmr_cc_chan u_tmr_cc_chan (
    .clk_i(clk), .rst_ni, .cnt_i, .dir_down_i, .upd_i, .cfg_capture_i, .cfg_mode_i,
    .cfg_pol_i, .cfg_preload_i, .cfg_edge_i, .cfg_flt_i, .cfg_psc_i, .ccr_we_i,
    .ccr_wdata_i, .flag_clr_i, .in_i, .out_o, .ccr_o, .flag_o, .ovc_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (free_run) cnt_i <= cnt_i + 1'b1;

  // monitor: pop one expected capture per raised flag, then clear it
  always @(negedge clk) begin
    if (mon_en && flag_o) begin
      if (exp_q.size() == 0) check("R5 unexpected capture", 32'(ccr_o), 32'hFFFF_FFFF);
      else check("R5 captured value", 32'(ccr_o), 32'(exp_q.pop_front()));
      mon_clr <= 1'b1;
    end else begin
      mon_clr <= 1'b0;
    end
  end

  task automatic cap_edge(input logic lvl, input bit expect_cap, input int n_flt,
                          output logic [CNT_W-1:0] e);
    logic [CNT_W-1:0] c;
    @(negedge clk); in_i = lvl;
    @(posedge clk); c = cnt_i;
    e = c + CNT_W'(1 + n_flt);
    if (expect_cap && mon_en) exp_q.push_back(e);
    repeat (16) @(negedge clk);
  endtask

  task automatic step(input logic [CNT_W-1:0] v, input logic d);
    @(negedge clk); cnt_i = v; dir_down_i = d;
    @(negedge clk);
  endtask

  task automatic write_ccr(input logic [CNT_W-1:0] v);
    @(negedge clk); ccr_we_i = 1'b1; ccr_wdata_i = v;
    @(negedge clk); ccr_we_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); man_clr = 1'b1;
    @(negedge clk); man_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] e, e1, e2;
    logic o0;
    repeat (3) @(negedge clk);
    check("R1 ccr reset", 32'(ccr_o), 0);
    check("R1 flag reset", 32'(flag_o), 0);
    check("R1 ovc reset", 32'(ovc_o), 0);
    check("R1 out reset", 32'(out_o), 0);
    rst_ni = 1'b1;
    free_run = 1'b1; mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R5 R3 rising edges only
    cap_edge(1'b1, 1, 1, e); cap_edge(1'b0, 0, 1, e);
    cap_edge(1'b1, 1, 1, e); cap_edge(1'b0, 0, 1, e);
    check("R3 rising drained", exp_q.size(), 0);
    cfg_edge_i = 2'd1;
    cap_edge(1'b1, 0, 1, e); cap_edge(1'b0, 1, 1, e);
    check("R3 falling drained", exp_q.size(), 0);
    cfg_edge_i = 2'd2;
    cap_edge(1'b1, 1, 1, e); cap_edge(1'b0, 1, 1, e);
    check("R3 both drained", exp_q.size(), 0);

    // R2 filter length 4 with a 3-cycle glitch, then length 8
    cfg_edge_i = 2'd0; cfg_flt_i = 2'd2;
    @(negedge clk); in_i = 1'b1; repeat (3) @(negedge clk); in_i = 1'b0;
    repeat (16) @(negedge clk);
    cap_edge(1'b1, 1, 4, e); cap_edge(1'b0, 0, 4, e);
    cfg_flt_i = 2'd3;
    cap_edge(1'b1, 1, 8, e); cap_edge(1'b0, 0, 8, e);
    check("R2 filter drained", exp_q.size(), 0);

    // R4 divide by 4
    cfg_flt_i = 2'd0; cfg_psc_i = 2'd2;
    for (int i = 1; i <= 8; i++) begin
      cap_edge(1'b1, (i % 4) == 0, 1, e);
      cap_edge(1'b0, 0, 1, e);
    end
    check("R4 prescale drained", exp_q.size(), 0);

    // R6 R7 overcapture
    cfg_psc_i = 2'd0; cfg_edge_i = 2'd2; mon_en = 1'b0;
    repeat (4) @(negedge clk);
    pulse_clr();
    cap_edge(1'b1, 0, 1, e1);
    check("R5 flag set", 32'(flag_o), 1);
    check("R5 first value", 32'(ccr_o), 32'(e1));
    check("R6 no ovc yet", 32'(ovc_o), 0);
    cap_edge(1'b0, 0, 1, e2);
    check("R6 ovc set", 32'(ovc_o), 1);
    check("R6 latest value", 32'(ccr_o), 32'(e2));
    pulse_clr();
    check("R7 flag cleared", 32'(flag_o), 0);
    check("R7 ovc cleared", 32'(ovc_o), 0);

    // compare mode
    free_run = 1'b0;
    @(negedge clk); cnt_i = 16'd100; cfg_capture_i = 1'b0; cfg_mode_i = 3'd6;
    write_ccr(16'd5);
    check("R12 direct write", 32'(ccr_o), 5);
    for (int v = 0; v < 10; v++) begin
      step(16'(v), 1'b0);
      check("R10 pwm A up", 32'(out_o), 32'(v < 5));
    end
    for (int v = 9; v >= 0; v--) begin
      step(16'(v), 1'b1);
      check("R10 pwm A down", 32'(out_o), 32'(v <= 5));
    end
    cfg_mode_i = 3'd7;
    for (int v = 0; v < 10; v++) begin
      step(16'(v), 1'b0);
      check("R10 pwm B up", 32'(out_o), 32'(!(v < 5)));
    end
    cfg_mode_i = 3'd6; cfg_pol_i = 1'b1;
    for (int v = 0; v < 10; v++) begin
      step(16'(v), 1'b0);
      check("R11 inverted polarity", 32'(out_o), 32'((v < 5) ^ 1));
    end
    cfg_pol_i = 1'b0;

    // R8 match flag
    step(16'd4, 1'b0);
    pulse_clr();
    check("R8 no match", 32'(flag_o), 0);
    step(16'd5, 1'b0);
    check("R8 match flag", 32'(flag_o), 1);
    pulse_clr();
    repeat (2) @(negedge clk);
    check("R8 held match once", 32'(flag_o), 0);

    // R9 output modes
    cfg_mode_i = 3'd3;
    step(16'd4, 1'b0); o0 = out_o;
    step(16'd5, 1'b0);
    check("R9 toggle once", 32'(out_o), 32'(!o0));
    cfg_mode_i = 3'd5; step(16'd0, 1'b0);
    check("R9 force high", 32'(out_o), 1);
    cfg_mode_i = 3'd4; step(16'd0, 1'b0);
    check("R9 force low", 32'(out_o), 0);
    cfg_mode_i = 3'd1; step(16'd5, 1'b0);
    check("R9 set on match", 32'(out_o), 1);
    cfg_mode_i = 3'd2; step(16'd0, 1'b0); step(16'd5, 1'b0);
    check("R9 clear on match", 32'(out_o), 0);

    // R12 preload
    cfg_preload_i = 1'b1;
    write_ccr(16'd9);
    repeat (2) @(negedge clk);
    check("R12 held until update", 32'(ccr_o), 5);
    @(negedge clk); upd_i = 1'b1;
    @(negedge clk); upd_i = 1'b0;
    check("R12 applied on update", 32'(ccr_o), 9);
    cfg_preload_i = 1'b0;

    // R13 capture mode ignores writes
    cfg_pol_i = 1'b1;
    @(negedge clk); cfg_capture_i = 1'b1;
    write_ccr(16'd3);
    @(negedge clk);
    check("R13 write ignored", 32'(ccr_o), 9);
    check("R13 out idle", 32'(out_o), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule